// File: doc/BRIEF.md
# Sliding-Window Jet Patch Trigger

This block scans a calorimeter grid of subregion energy sums for jets. The grid is 12 rows by 17 columns, 204 subregions in all. It arrives one full column per accepted beat, leftmost column first. For each column it forms every square patch of n by n subregions that ends on that column, with n set to 1, 2 or 3 for the event. It compares each patch sum with a threshold that grows with the event multiplicity. It latches a trigger flag and the grid position of the first patch whose sum exceeds that threshold.

An event opens with a one-cycle `start` pulse, which samples the patch size code, the base threshold, the multiplicity and the multiplicity gain. A 1x1 patch is compared with the threshold directly. Larger patches combine n-row vertical sums of the current column with those of the previous n-1 columns, which the block keeps as raw column copies. A single-cycle `done` marks the acceptance of the seventeenth column. Patch sums are 20 bits wide.

Top module: `jet_patch_trigger`

## Requirements
- R1: After reset, `jet_trig`, `done`, `hit_row` and `hit_col` are all 0.
- R2: `size_code` 1, 2 or 3 selects a patch of that side, and code 0 selects a side of 1. The code is sampled only on `start`; changes during an event have no effect on that event.
- R3: On `start` the threshold is set to `thr_base + floor(mult * mult_gain / 16)`. It saturates at 1048575 when that sum does not fit in 20 bits.
- R4: A patch fires only when its sum is strictly greater than the threshold. A sum equal to the threshold does not fire.
- R5: Only patches lying wholly inside the grid are tested. Their top row lies in 0..12-n and their left column in 0..17-n. No patch wraps across a row or column edge.
- R6: Position encoding: a column number is its 0-based arrival order within the event, and row i is carried in `col_data[i*16 +: 16]`. `hit_row` reports the top row and `hit_col` the left column of the first firing patch. Patches are ranked first by the column on which they complete (earlier first), then by lower top row.
- R7: Once set, `jet_trig`, `hit_row` and `hit_col` hold their values until the next `start`.
- R8: `done` is high for exactly one cycle: the cycle after the edge that accepts the 17th column of an event. The trigger result for the full grid is valid in that same cycle.
- R9: `col_valid` is ignored outside an event, meaning before the first `start` and after `done`. It then changes neither `done` nor `jet_trig`.
- R10: A `start` during an event abandons it. `jet_trig`, `hit_row` and `hit_col` clear to 0, and column counting begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens an event and samples its settings |
| size_code | input | 2 | Patch side code (0 behaves as 1) |
| thr_base | input | 20 | Base threshold |
| mult | input | 12 | Event multiplicity |
| mult_gain | input | 4 | Multiplicity gain in sixteenths |
| col_valid | input | 1 | A column is present on col_data |
| col_data | input | 192 | Twelve 16-bit subregion sums, row i at bits i*16 +: 16 |
| jet_trig | output | 1 | A patch above threshold was found |
| hit_row | output | 4 | Top row of the first firing patch |
| hit_col | output | 5 | Left column of the first firing patch |
| done | output | 1 | One-cycle pulse after the last column |

## Verification
Each accepted column registers its trigger result on the same clock edge that accepts it. The bench therefore reads `jet_trig`, `hit_row`, `hit_col` and `done` one time unit after that edge, and never at an edge. The full-grid result and `done` are checked right after the edge that takes the 17th column. `done` is also checked to be low one cycle earlier and one cycle later. A restart and idle-cycle columns are checked cycle by cycle after each edge. This shows that the result changes only on the edges the requirements name.

// File: rtl/jet_patch_trigger.sv
module jet_patch_trigger #(
  parameter int ROWS = 12,
  parameter int COLS = 17,
  parameter int EW   = 16,
  parameter int SW   = 20,
  parameter int MW   = 12,
  parameter int GW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           size_code,
  input  logic [SW-1:0]        thr_base,
  input  logic [MW-1:0]        mult,
  input  logic [GW-1:0]        mult_gain,
  input  logic                 col_valid,
  input  logic [ROWS*EW-1:0]   col_data,
  output logic                 jet_trig,
  output logic [$clog2(ROWS)-1:0] hit_row,
  output logic [$clog2(COLS)-1:0] hit_col,
  output logic                 done
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);
  localparam int PW = MW + GW;

  logic               busy;
  logic [CW-1:0]      col_cnt;
  logic [1:0]         n_q;
  logic [SW-1:0]      thr_q;
  logic [ROWS*EW-1:0] prev1, prev2;

  // threshold with multiplicity correction, saturating
  logic [PW-1:0] prod;
  logic [SW:0]   thr_sum;
  logic [SW-1:0] thr_next;
  logic [1:0]    n_next;
  assign prod     = {{GW{1'b0}}, mult} * {{MW{1'b0}}, mult_gain};
  assign thr_sum  = {1'b0, thr_base} + (SW+1)'(prod >> 4);
  assign thr_next = thr_sum[SW] ? {SW{1'b1}} : thr_sum[SW-1:0];
  assign n_next   = (size_code == 2'd0) ? 2'd1 : size_code;

  function automatic logic [SW-1:0] vsum(input logic [ROWS*EW-1:0] col,
                                         input int r, input logic [1:0] n);
    logic [SW-1:0] acc;
    int idx;
    acc = '0;
    for (int k = 0; k < 3; k++) begin
      idx = (r + k < ROWS) ? r + k : 0;
      if (k < int'(n) && r + k < ROWS)
        acc = acc + SW'(col[idx*EW +: EW]);
    end
    return acc;
  endfunction

  logic [SW-1:0] psum [ROWS];
  logic [ROWS-1:0] hit;
  logic col_ok;
  assign col_ok = (int'(col_cnt) + 1 >= int'(n_q));

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign psum[r] = vsum(col_data, r, n_q)
                   + ((n_q >= 2'd2) ? vsum(prev1, r, n_q) : '0)
                   + ((n_q == 2'd3) ? vsum(prev2, r, n_q) : '0);
    assign hit[r] = (r + int'(n_q) <= ROWS) && col_ok && (psum[r] > thr_q);
  end

  logic [RW-1:0] first_row;
  always_comb begin
    first_row = '0;
    for (int r = ROWS - 1; r >= 0; r--)
      if (hit[r]) first_row = RW'(r);
  end

  logic [CW-1:0] anchor_col;
  assign anchor_col = CW'(int'(col_cnt) + 1 - int'(n_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      col_cnt  <= '0;
      n_q      <= 2'd1;
      thr_q    <= '0;
      prev1    <= '0;
      prev2    <= '0;
      jet_trig <= 1'b0;
      hit_row  <= '0;
      hit_col  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        col_cnt  <= '0;
        n_q      <= n_next;
        thr_q    <= thr_next;
        jet_trig <= 1'b0;
        hit_row  <= '0;
        hit_col  <= '0;
      end else if (busy && col_valid) begin
        prev2   <= prev1;
        prev1   <= col_data;
        col_cnt <= col_cnt + 1'b1;
        if (|hit && !jet_trig) begin
          jet_trig <= 1'b1;
          hit_row  <= first_row;
          hit_col  <= anchor_col;
        end
        if (int'(col_cnt) == COLS - 1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_trig_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (jet_trig && !start) |=> (jet_trig && $stable(hit_row) && $stable(hit_col)));
  p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!jet_trig && !done && hit_row == '0 && hit_col == '0));
  p_anchor_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    jet_trig |-> ((int'(hit_row) + int'(n_q) <= ROWS) && (int'(hit_col) + int'(n_q) <= COLS)));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(jet_trig) && !done));
  p_size_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    n_q != 2'd0);
endmodule

// File: tb/jet_patch_trigger_test.sv
module jet_patch_trigger_test;
  localparam int ROWS = 12, COLS = 17, EW = 16;
  localparam int THR_MAX = 1048575;

  logic clk = 0, rst_n = 0, start = 0, col_valid = 0;
  logic [1:0] size_code = 1;
  logic [19:0] thr_base = 0;
  logic [11:0] mult = 0;
  logic [3:0] mult_gain = 0;
  logic [ROWS*EW-1:0] col_data = '0;
  logic jet_trig, done;
  logic [3:0] hit_row;
  logic [4:0] hit_col;

  jet_patch_trigger uut (.clk(clk), .rst_n(rst_n), .start(start), .size_code(size_code),
    .thr_base(thr_base), .mult(mult), .mult_gain(mult_gain), .col_valid(col_valid),
    .col_data(col_data), .jet_trig(jet_trig), .hit_row(hit_row), .hit_col(hit_col),
    .done(done));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [15:0] g [COLS][ROWS];
  int e_trig, e_row, e_col;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [ROWS*EW-1:0] colv(int c);
    logic [ROWS*EW-1:0] v;
    for (int r = 0; r < ROWS; r++) v[r*EW +: EW] = g[c][r];
    return v;
  endfunction

  task automatic clear_grid();
    for (int c = 0; c < COLS; c++) for (int r = 0; r < ROWS; r++) g[c][r] = 0;
  endtask

  task automatic model(int code, int base, int mu, int gn);
    int n, t, s;
    n = (code == 0) ? 1 : code;
    t = base + ((mu * gn) >> 4);
    if (t > THR_MAX) t = THR_MAX;
    e_trig = 0; e_row = 0; e_col = 0;
    for (int c = n - 1; c < COLS && e_trig == 0; c++)
      for (int r = 0; r + n <= ROWS && e_trig == 0; r++) begin
        s = 0;
        for (int dc = 0; dc < n; dc++)
          for (int dr = 0; dr < n; dr++) s += g[c - dc][r + dr];
        if (s > t) begin e_trig = 1; e_row = r; e_col = c - n + 1; end
      end
  endtask

  task automatic run_event(string req, int code, int base, int mu, int gn, bit gaps, bit flip);
    model(code, base, mu, gn);
    @(negedge clk);
    size_code = 2'(code); thr_base = 20'(base); mult = 12'(mu); mult_gain = 4'(gn);
    start = 1;
    @(negedge clk);
    start = 0;
    if (flip) begin size_code = 2'd1; thr_base = 20'hFFFFF; mult = 0; mult_gain = 0; end
    for (int c = 0; c < COLS; c++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        col_valid = 0; col_data = {ROWS{16'hFFFF}};
        @(negedge clk);
      end
      col_valid = 1; col_data = colv(c);
      @(posedge clk); #1;
      if (c == COLS - 2) check({req, " R8 done early"}, int'(done), 0);
      @(negedge clk);
      col_valid = 0;
      if (c == COLS - 1) begin
        // still inside the cycle right after the last accepting edge
        check({req, " R8 done"}, int'(done), 1);
        check({req, " R4 trig"}, int'(jet_trig), e_trig);
        check({req, " R6 row"}, int'(hit_row), e_row);
        check({req, " R6 col"}, int'(hit_col), e_col);
      end
    end
    @(posedge clk); #1;
    check({req, " R8 done falls"}, int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clear_grid();
    repeat (3) @(posedge clk);
    #1;
    check("R1 trig", int'(jet_trig), 0);
    check("R1 done", int'(done), 0);
    check("R1 row", int'(hit_row), 0);
    check("R1 col", int'(hit_col), 0);
    @(negedge clk) rst_n = 1;

    // R9: columns before any start
    col_valid = 1; col_data = {ROWS{16'hFFFF}};
    repeat (20) begin @(posedge clk); #1; check("R9 pre-start done", int'(done), 0); end
    @(negedge clk) col_valid = 0;

    // R4 equal does not fire, one below fires
    g[7][5] = 1000;
    run_event("R4 equal", 1, 1000, 0, 0, 0, 0);
    run_event("R4 above", 1, 999, 0, 0, 0, 0);
    run_event("R2 code0", 0, 999, 0, 0, 0, 0);

    // R5 corner
    clear_grid(); g[16][11] = 500;
    run_event("R5 corner n3", 3, 499, 0, 0, 0, 0);
    check("R5 corner row", e_row, 9);
    run_event("R5 corner n2", 2, 499, 0, 0, 0, 0);
    // R5 no wrap across row edge
    clear_grid(); g[3][11] = 300; g[4][0] = 300;
    run_event("R5 nowrap", 2, 400, 0, 0, 0, 0);
    check("R5 nowrap model", e_trig, 0);

    // R6 ordering
    clear_grid(); g[2][8] = 900; g[5][1] = 900;
    run_event("R6 by column", 1, 800, 0, 0, 0, 0);
    clear_grid(); g[4][9] = 900; g[4][3] = 900;
    run_event("R6 by row", 1, 800, 0, 0, 0, 0);

    // R3 multiplicity: 1000 + 160*10/16 = 1100
    clear_grid(); g[6][2] = 1100;
    run_event("R3 corr equal", 1, 1000, 160, 10, 0, 0);
    g[6][2] = 1101;
    run_event("R3 corr above", 1, 1000, 160, 10, 0, 0);
    // R3 saturation: unsaturated sum would wrap to a small value
    for (int c = 0; c < COLS; c++) for (int r = 0; r < ROWS; r++) g[c][r] = 16'hFFFF;
    run_event("R3 saturate", 3, THR_MAX - 10, 4095, 15, 0, 0);

    // R2 size latched at start
    clear_grid(); g[4][4] = 400; g[5][5] = 400;
    run_event("R2 latched", 3, 700, 0, 0, 1, 1);

    // R9 after done: hot columns must not change anything
    begin
      int tr;
      tr = int'(jet_trig);
      @(negedge clk);
      col_valid = 1; col_data = {ROWS{16'hFFFF}};
      for (int i = 0; i < 20; i++) begin
        @(posedge clk); #1;
        check("R9 idle done", int'(done), 0);
        check("R9 idle trig", int'(jet_trig), tr);
      end
      @(negedge clk) col_valid = 0;
    end

    // R10 restart
    clear_grid(); for (int r = 0; r < ROWS; r++) g[0][r] = 50;
    @(negedge clk); size_code = 1; thr_base = 10; mult = 0; mult_gain = 0; start = 1;
    @(negedge clk); start = 0;
    for (int c = 0; c < 3; c++) begin
      col_valid = 1; col_data = colv(c);
      @(negedge clk);
    end
    col_valid = 0; #1;
    check("R7 trig set", int'(jet_trig), 1);
    @(posedge clk); #1;
    check("R7 hold", int'(jet_trig), 1);
    clear_grid();
    run_event("R10 restart", 1, 10, 0, 0, 0, 0);
    check("R10 cleared", int'(jet_trig), 0);

    // random events
    for (int i = 0; i < 40; i++) begin
      int code, base;
      for (int c = 0; c < COLS; c++)
        for (int r = 0; r < ROWS; r++) g[c][r] = 16'($urandom % 2000);
      code = $urandom % 4;
      base = (code >= 2) ? 8000 + $urandom % 14000 : 1500 + $urandom % 600;
      run_event("R6 random", code, base, $urandom % 4096, $urandom % 16, 1, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule